// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block makes three clock-enable strobes from one reference clock. The strobes pace a processor clock domain, a main-interconnect domain and a peripheral-bus domain. Each strobe runs at the reference rate divided by a power of two (1, 2, 4 or 8). The power is a 2-bit exponent field, and all three fields share one configuration word. Downstream logic either gates its registers with the strobe or feeds it to a clock-gating cell.

Software programs the ratios through a small synchronous access port. It reads the word, changes one field and writes the whole word back. The peripheral-bus channel must never run at the full reference rate. A write that would give it exponent 0 leaves that field at its old value. A new ratio does not cut into a period already under way. Each channel adopts the new exponent only on the cycle its own divide counter wraps, so every low gap is the full old length or the full new length.

Top module: `busclk_ratio_div`

## Requirements
- R1: After reset the stored word reads 0x10. That is: processor exponent 0, interconnect exponent 0, peripheral exponent 1. After the reset period the processor and interconnect strobes repeat every cycle and the peripheral strobe every 2 cycles.
- R2: A read request drives `acc_rdata` on the following cycle. A read at byte address 0x08 returns the stored fields in bits [5:0] and zeros in bits [31:6]. A read at any other address returns 0.
- R3: A write at byte address 0x08 stores the processor exponent from bits [1:0], the interconnect exponent from bits [3:2] and the peripheral exponent from bits [5:4]. Bits [31:6] are ignored. A write at any other address leaves the stored word unchanged.
- R4: With exponent e, a channel's strobe is high for one cycle every 2^e cycles. With e = 0 it stays high on every cycle.
- R5: When a write puts 0 in bits [5:4], the peripheral exponent keeps its previous value. The other two fields of the same write still take effect. The stored peripheral exponent is never 0.
- R6: After a field change, the first strobe gap that ends after the write still has the old length. The gap after it has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| cpu_stb | output | 1 | Processor-domain clock enable |
| axi_stb | output | 1 | Interconnect-domain clock enable |
| ahb_stb | output | 1 | Peripheral-bus clock enable |

## Verification
A table of configuration words is written one after another. Each row sets a different exponent in every channel and is checked by readback and by the measured strobe period of each channel. This shows that each field lands in the right channel and that exponents 0 to 3 give periods 1, 2, 4 and 8. Some rows carry junk in the upper bits, and some put 0 in the peripheral field. These rows separate correct masking and zero-rejection from a plain copy of the written word. Directed change-over cases go slow-to-fast, fast-to-slow and from exponent 0. They compare the strobe gap that straddles the write with the gap after it, which shows whether a ratio switch waits for the counter wrap.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  typedef enum logic [1:0] {
    CH_CPU = 2'd0,
    CH_AXI = 2'd1,
    CH_AHB = 2'd2
  } busclk_ch_e;

  localparam int unsigned BUSCLK_NUM_CH = 3;
endpackage

// File: rtl/busclk_cfg_reg.sv
module busclk_cfg_reg #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 2,
  parameter int unsigned NUM_CH  = 3,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h08,
  parameter logic [NUM_CH*FIELD_W-1:0] RST_CFG = 6'b01_00_00,
  parameter logic [NUM_CH-1:0] NOZERO_MASK = 3'b100
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_en,
  input  logic                      acc_we,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic [DATA_W-1:0]         acc_rdata,
  output logic [NUM_CH*FIELD_W-1:0] cfg_q
);
  localparam int unsigned TOT_W = NUM_CH * FIELD_W;

  logic                 hit;
  logic                 wr_hit;
  logic [TOT_W-1:0]     cfg_next;
  logic                 unused_wdata;

  assign hit          = (acc_addr == CFG_ADDR);
  assign wr_hit       = acc_en && acc_we && hit;
  assign unused_wdata = ^acc_wdata[DATA_W-1:TOT_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_field
    logic [FIELD_W-1:0] new_f;
    assign new_f = acc_wdata[i*FIELD_W +: FIELD_W];
    if (NOZERO_MASK[i]) begin : g_guard
      assign cfg_next[i*FIELD_W +: FIELD_W] =
        (new_f == '0) ? cfg_q[i*FIELD_W +: FIELD_W] : new_f;
    end else begin : g_plain
      assign cfg_next[i*FIELD_W +: FIELD_W] = new_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RST_CFG;
    end else if (wr_hit) begin
      cfg_q <= cfg_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
    end else if (acc_en && !acc_we) begin
      acc_rdata <= hit ? {{(DATA_W-TOT_W){1'b0}}, cfg_q} : '0;
    end
  end
endmodule

// File: rtl/busclk_chan.sv
module busclk_chan #(
  parameter int unsigned FIELD_W = 2,
  parameter logic [FIELD_W-1:0] RST_EXP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] exp_in,
  output logic               stb
);
  localparam int unsigned CNT_W = (1 << FIELD_W) - 1;

  logic [FIELD_W-1:0] act_exp;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   limit;
  logic               wrap;

  assign limit = {CNT_W{1'b1}} >> (CNT_W - act_exp);
  assign wrap  = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_exp <= RST_EXP;
      stb     <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      act_exp <= exp_in;
      stb     <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      stb     <= 1'b0;
    end
  end
endmodule

// File: rtl/busclk_ratio_div.sv
module busclk_ratio_div
  import busclk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h08,
  parameter logic [BUSCLK_NUM_CH*FIELD_W-1:0] RST_CFG = 6'b01_00_00,
  parameter logic [BUSCLK_NUM_CH-1:0] NOZERO_MASK = 3'b100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              cpu_stb,
  output logic              axi_stb,
  output logic              ahb_stb
);
  localparam int unsigned TOT_W = BUSCLK_NUM_CH * FIELD_W;

  logic [TOT_W-1:0]         cfg_q;
  logic [BUSCLK_NUM_CH-1:0] stb_v;

  busclk_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
    .NUM_CH(BUSCLK_NUM_CH), .CFG_ADDR(CFG_ADDR),
    .RST_CFG(RST_CFG), .NOZERO_MASK(NOZERO_MASK)
  ) u_cfg (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .cfg_q(cfg_q)
  );

  for (genvar c = 0; c < BUSCLK_NUM_CH; c++) begin : g_ch
    busclk_chan #(
      .FIELD_W(FIELD_W),
      .RST_EXP(RST_CFG[c*FIELD_W +: FIELD_W])
    ) u_chan (
      .clk(clk), .rst(rst),
      .exp_in(cfg_q[c*FIELD_W +: FIELD_W]),
      .stb(stb_v[c])
    );
  end

  assign cpu_stb = stb_v[CH_CPU];
  assign axi_stb = stb_v[CH_AXI];
  assign ahb_stb = stb_v[CH_AHB];
endmodule

// File: rtl/busclk_ratio_chk.sv
module busclk_ratio_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TOT_W  = 6,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h08
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_rdata,
  input logic [TOT_W-1:0]  cfg_q,
  input logic              ahb_stb
);
  // R2
  rd_miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && acc_addr != CFG_ADDR) |=> (acc_rdata == '0));

  // R2
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acc_rdata[DATA_W-1:TOT_W] == '0);

  // R3
  wr_miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr != CFG_ADDR) |=> $stable(cfg_q));

  // R5
  ahb_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q[TOT_W-1 -: 2] != 2'b00);

  // R4
  ahb_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ahb_stb |=> !ahb_stb);
endmodule

bind busclk_ratio_div busclk_ratio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOT_W(TOT_W), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .cfg_q(cfg_q),
  .ahb_stb(ahb_stb)
);

// File: tb/sim_busclk_ratio_div.sv
`timescale 1ns/1ps
module sim_busclk_ratio_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        cpu_stb, axi_stb, ahb_stb;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int scnt [3];
  int slast[3];
  int sgap [3];
  logic [2:0] stbv;

  always #4 clk = ~clk;

  busclk_ratio_div u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .cpu_stb(cpu_stb), .axi_stb(axi_stb), .ahb_stb(ahb_stb)
  );

  assign stbv = {ahb_stb, axi_stb, cpu_stb};

  initial begin
    for (int c = 0; c < 3; c++) begin scnt[c] = 0; slast[c] = 0; sgap[c] = 0; end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      for (int c = 0; c < 3; c++) begin
        if (stbv[c]) begin
          scnt[c]  <= scnt[c] + 1;
          sgap[c]  <= cyc - slast[c];
          slast[c] <= cyc;
        end
      end
    end
  end

  // vector table: write data, expected readback
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_001B, 32'h0000_001B},
    {32'hFFFF_FFE4, 32'h0000_0024},
    {32'h0000_0000, 32'h0000_0020},
    {32'h0000_003F, 32'h0000_003F},
    {32'h0000_0006, 32'h0000_0036},
    {32'hA5A5_A5D9, 32'h0000_0019}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
  endtask

  task automatic wait_strobes(input int ch, input int target);
    while (scnt[ch] < target) @(posedge clk);
  endtask

  task automatic period_check(input int ch, input int e, input string req);
    int s0;
    @(posedge clk);
    s0 = scnt[ch];
    wait_strobes(ch, s0 + 3);
    chk(sgap[ch] == (1 << e), req, sgap[ch], 1 << e);
  endtask

  task automatic change_check(input int ch, input int old_e, input int new_e);
    int s0;
    logic [31:0] w;
    w = 32'h10;
    if (ch == 2) w = 32'(old_e) << 4;
    else w = w | (32'(old_e) << (2 * ch));
    wr(8'h08, w);
    period_check(ch, old_e, "R6 settle");
    if (ch == 2) w = 32'(new_e) << 4;
    else w = 32'h10 | (32'(new_e) << (2 * ch));
    wr(8'h08, w);
    @(posedge clk);
    s0 = scnt[ch];
    wait_strobes(ch, s0 + 1);
    chk(sgap[ch] == (1 << old_e), "R6 old gap", sgap[ch], 1 << old_e);
    wait_strobes(ch, s0 + 2);
    chk(sgap[ch] == (1 << new_e), "R6 new gap", sgap[ch], 1 << new_e);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h08, d);
    chk(d == 32'h10, "R1 reset readback", d, 32'h10);
    period_check(0, 0, "R1 cpu reset period");
    period_check(1, 0, "R1 axi reset period");
    period_check(2, 1, "R1 ahb reset period");

    // R3/R4/R5 vector walk
    for (int v = 0; v < 6; v++) begin
      wr(8'h08, VEC[v][63:32]);
      rd(8'h08, d);
      chk(d == VEC[v][31:0], "R3 R5 vector readback", d, VEC[v][31:0]);
      for (int c = 0; c < 3; c++)
        period_check(c, int'(VEC[v][2*c +: 2]), "R4 channel period");
    end

    // R2 read of another address
    rd(8'h0C, d);
    chk(d == 32'h0, "R2 miss read", d, 0);
    rd(8'h00, d);
    chk(d == 32'h0, "R2 miss read low", d, 0);

    // R3 write to another address ignored
    wr(8'h04, 32'h0000_002A);
    rd(8'h08, d);
    chk(d == 32'h19, "R3 miss write ignored", d, 32'h19);
    period_check(0, 1, "R3 cpu unchanged after miss write");

    // R5 zero in AHB with other fields updated
    wr(8'h08, 32'h0000_000E);
    rd(8'h08, d);
    chk(d == 32'h1E, "R5 zero ahb kept", d, 32'h1E);
    period_check(2, 1, "R5 ahb period kept");

    // R6 change-over cases
    change_check(0, 3, 0);
    change_check(1, 0, 2);
    change_check(2, 3, 1);
    change_check(0, 1, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule